// File: doc/BRIEF.md
# IR Carrier Modulated Transmitter

This block plays back a queue of infrared pulse records on a single output pin. Each record holds a level (mark or space) and a duration. The records wait in an eight-entry transmit queue. A sequencer takes them one at a time and times each one with an 18-bit down-counter. That counter is stepped by a programmable prescaler. When one record ends and another is waiting, the next one starts on the same clock edge, so a message has no gaps between its pulses.

When modulation is on, a carrier of sixteen prescaler ticks per period is gated onto the pin, with a high time that is set in sixteenths. A polarity control picks whether the bursts go on marks or on spaces. When modulation is off, the pin simply shows the record level. A service request tells the feeding logic when the queue needs refilling, using either a half-empty or an empty watermark. The interrupt is that request masked by its own enable. A busy flag shows that a record is being played.

Top module: `irtx_modulator`

## Requirements
- R1: After reset, ir_out, busy, fifo_full and irq are 0, fifo_level is 0, and svc_req is 1.
- R2: The queue holds up to 8 records. fifo_level reports the count and fifo_full is 1 at 8. A write made while the queue is full is dropped, even if a record leaves in the same cycle.
- R3: Record encoding: wr_data[15:0] is a duration D and wr_data[16] is the level (1 = mark). A record plays for exactly (4*D+4)*(clk_div+1) clock cycles.
- R4: While tx_enable is high, a waiting record starts on the edge where the previous one ends. busy stays high with no gap, and the next record is taken without an idle cycle.
- R5: During a burst, the prescaler ticks once every clk_div+1 cycles, counted from the first cycle of the burst. The carrier phase is the number of ticks since the burst started, modulo 16. The carrier is high while the phase is at most duty_code, so it is high for (duty_code+1) of every 16 ticks.
- R6: With mod_enable=1 and invert_burst=0, ir_out carries the carrier during marks and is 0 during spaces.
- R7: With mod_enable=1 and invert_burst=1, ir_out carries the carrier during spaces and is 0 during marks.
- R8: With mod_enable=0, ir_out equals the level of the record being played, with no carrier.
- R9: When the queue is empty as the current record ends, busy falls and ir_out returns to 0 on that edge.
- R10: svc_req is 1 when fifo_level <= 4 while wm_empty=0, and is 1 only when fifo_level = 0 while wm_empty=1.
- R11: irq equals svc_req AND irq_enable.
- R12: While tx_enable is 0, no record is taken and the record being played is abandoned: busy and ir_out go to 0 on the next edge. Queued records stay, and writes are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 17 | Record: [16] level, [15:0] duration |
| tx_enable | input | 1 | Allow playback |
| mod_enable | input | 1 | Gate the carrier onto the pin |
| invert_burst | input | 1 | Put bursts on spaces instead of marks |
| duty_code | input | 4 | Carrier high time, (n+1)/16 |
| clk_div | input | 16 | Prescaler divide value, tick every clk_div+1 cycles |
| wm_empty | input | 1 | Service watermark: 1 = empty, 0 = half empty |
| irq_enable | input | 1 | Interrupt mask |
| ir_out | output | 1 | IR output pin |
| busy | output | 1 | A record is being played |
| fifo_level | output | 4 | Records queued |
| fifo_full | output | 1 | Queue full |
| svc_req | output | 1 | Queue service request |
| irq | output | 1 | Masked service request |

## Verification
The assertions assume that clk_div and duty_code stay constant while busy is high. The prescaler spacing and carrier phase checks depend on this, because changing the divide value mid-count would shift the tick grid. The stimulus changes these controls only while the transmitter is idle or disabled. It writes records only at falling clock edges, so each write lands on a single edge. Records are queued while tx_enable is low and then released, so that back-to-back playback starts from a known, full queue.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

   typedef enum logic [1:0] {
      DRV_IDLE  = 2'd0,
      DRV_LEVEL = 2'd1,
      DRV_BURST = 2'd2
   } irtx_drive_e;

   function automatic irtx_drive_e pick_drive(input logic playing, input logic modulate);
      if (!playing)      return DRV_IDLE;
      else if (!modulate) return DRV_LEVEL;
      else               return DRV_BURST;
   endfunction

endpackage

// File: rtl/irtx_fifo.sv
module irtx_fifo #(
   parameter int WIDTH = 17,
   parameter int DEPTH = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             pop,
   output logic [WIDTH-1:0] rd_data,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("irtx_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 2) begin : g_bad_width
      $error("irtx_fifo: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_nx, rd_ptr_nx;
   logic [CNT_W-1:0] count_q;
   logic             push;

   assign full    = (count_q == CNT_W'(DEPTH));
   assign empty   = (count_q == '0);
   assign push    = wr_en && !full;
   assign rd_data = mem_q[rd_ptr_q];
   assign count   = count_q;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
      assign wr_ptr_nx = wr_ptr_q + 1'b1;
      assign rd_ptr_nx = rd_ptr_q + 1'b1;
   end else begin : g_cmp_wrap
      assign wr_ptr_nx = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      assign rd_ptr_nx = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push) mem_q[wr_ptr_q] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (push) wr_ptr_q <= wr_ptr_nx;
         if (pop)  rd_ptr_q <= rd_ptr_nx;
         case ({push, pop})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !pop) |=> $stable(count_q)); // R2

   AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R4

endmodule

// File: rtl/irtx_prescaler.sv
module irtx_prescaler #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   if (DIV_W < 1) begin : g_bad_div
      $error("irtx_prescaler: DIV_W must be positive");
   end

   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == div);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt_q <= '0;
      else if (cnt_q == div) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
   end

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> (!tick || !$stable(div))); // R5

endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
   parameter int STEP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic [STEP_W-1:0] duty,
   output logic              carrier_hi
);

   if (STEP_W < 1) begin : g_bad_step
      $error("irtx_carrier: STEP_W must be positive");
   end

   logic [STEP_W-1:0] phase_q;

   assign carrier_hi = (phase_q <= duty);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) phase_q <= '0;
      else if (tick)      phase_q <= phase_q + 1'b1;
   end

   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(phase_q)); // R5

endmodule

// File: rtl/irtx_sequencer.sv
module irtx_sequencer #(
   parameter int DUR_W  = 16,
   parameter int FRAC_W = 2,
   localparam int TIMER_W = DUR_W + FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             fifo_empty,
   input  logic [DUR_W-1:0] rec_dur,
   input  logic             rec_mark,
   input  logic             tick,
   output logic             pop,
   output logic             busy,
   output logic             level
);

   if (FRAC_W < 0 || DUR_W < 1) begin : g_bad_timer
      $error("irtx_sequencer: bad timer widths");
   end

   logic [TIMER_W-1:0] timer_q;
   logic               busy_q, level_q;
   logic               last_tick, start;

   assign last_tick = busy_q && tick && (timer_q == '0);
   assign start     = enable && !fifo_empty && (!busy_q || last_tick);
   assign pop       = start;
   assign busy      = busy_q;
   assign level     = level_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         busy_q  <= 1'b0;
         timer_q <= '0;
         level_q <= 1'b0;
      end else if (start) begin
         busy_q  <= 1'b1;
         timer_q <= {rec_dur, {FRAC_W{1'b1}}};
         level_q <= rec_mark;
      end else if (last_tick) begin
         busy_q  <= 1'b0;
         level_q <= 1'b0;
      end else if (busy_q && tick) begin
         timer_q <= timer_q - 1'b1;
      end
   end

   AST_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && last_tick && !fifo_empty) |=> busy_q); // R4

endmodule

// File: rtl/irtx_modulator.sv
module irtx_modulator #(
   parameter int DEPTH  = 8,
   parameter int DUR_W  = 16,
   parameter int FRAC_W = 2,
   parameter int DIV_W  = 16,
   parameter int STEP_W = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [DUR_W:0]             wr_data,
   input  logic                       tx_enable,
   input  logic                       mod_enable,
   input  logic                       invert_burst,
   input  logic [STEP_W-1:0]          duty_code,
   input  logic [DIV_W-1:0]           clk_div,
   input  logic                       wm_empty,
   input  logic                       irq_enable,
   output logic                       ir_out,
   output logic                       busy,
   output logic [$clog2(DEPTH+1)-1:0] fifo_level,
   output logic                       fifo_full,
   output logic                       svc_req,
   output logic                       irq
);
   import irtx_pkg::*;

   localparam int REC_W = DUR_W + 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int HALF  = DEPTH / 2;

   logic [REC_W-1:0] rec;
   logic [CNT_W-1:0] count;
   logic             empty, pop, tick, carrier_hi, level;
   irtx_drive_e      drive;

   irtx_fifo #(.WIDTH(REC_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
      .rd_data(rec), .count(count), .full(fifo_full), .empty(empty)
   );

   irtx_sequencer #(.DUR_W(DUR_W), .FRAC_W(FRAC_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .enable(tx_enable), .fifo_empty(empty),
      .rec_dur(rec[DUR_W-1:0]), .rec_mark(rec[DUR_W]), .tick(tick),
      .pop(pop), .busy(busy), .level(level)
   );

   irtx_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(busy), .div(clk_div), .tick(tick)
   );

   irtx_carrier #(.STEP_W(STEP_W)) u_car (
      .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick), .duty(duty_code),
      .carrier_hi(carrier_hi)
   );

   assign fifo_level = count;
   assign svc_req    = wm_empty ? (count == '0) : (count <= CNT_W'(HALF));
   assign irq        = svc_req && irq_enable;
   assign drive      = pick_drive(busy, mod_enable);

   always_comb begin
      case (drive)
         DRV_LEVEL: ir_out = level;
         DRV_BURST: ir_out = (level ^ invert_burst) && carrier_hi;
         default:   ir_out = 1'b0;
      endcase
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ir_out); // R9

endmodule

// File: tb/irtx_modulator_tb.sv
`timescale 1ns/1ps
module irtx_modulator_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [16:0] wr_data = '0;
   logic        tx_enable = 1'b0, mod_enable = 1'b0, invert_burst = 1'b0;
   logic [3:0]  duty_code = 4'd7;
   logic [15:0] clk_div = 16'd0;
   logic        wm_empty = 1'b0, irq_enable = 1'b0;
   logic        ir_out, busy, fifo_full, svc_req, irq;
   logic [3:0]  fifo_level;

   int checks = 0, errors = 0, cycles = 0;
   bit chk_on = 0;

   irtx_modulator u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .tx_enable(tx_enable), .mod_enable(mod_enable), .invert_burst(invert_burst),
      .duty_code(duty_code), .clk_div(clk_div), .wm_empty(wm_empty),
      .irq_enable(irq_enable), .ir_out(ir_out), .busy(busy),
      .fifo_level(fifo_level), .fifo_full(fifo_full), .svc_req(svc_req), .irq(irq)
   );

   always #4 clk = ~clk;

   // behavioural reference model
   logic [16:0] q[$];
   bit  m_active = 0, m_level = 0;
   int  m_rem = 0, m_elapsed = 0;

   task automatic m_load();
      logic [16:0] r;
      r = q.pop_front();
      m_rem   = (4 * int'(r[15:0]) + 4) * (int'(clk_div) + 1);
      m_level = r[16];
   endtask

   always @(posedge clk) begin
      int size0;
      size0 = q.size();
      if (!rst_n) begin
         q.delete();
         m_active = 0; m_level = 0; m_rem = 0; m_elapsed = 0;
      end else begin
         if (!tx_enable) m_active = 0;
         else if (m_active) begin
            m_rem--; m_elapsed++;
            if (m_rem == 0) begin
               if (size0 > 0) m_load();
               else m_active = 0;
            end
         end else if (size0 > 0) begin
            m_load(); m_active = 1; m_elapsed = 0;
         end
         if (wr_en && size0 < 8) q.push_back(wr_data);
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      #2;
      if (chk_on) begin
         bit e_out, e_svc;
         string tag;
         if (!m_active) begin e_out = 0; tag = "R9 idle output"; end
         else if (!mod_enable) begin e_out = m_level; tag = "R8 level output"; end
         else begin
            e_out = (m_level ^ invert_burst) &&
                    (((m_elapsed / (int'(clk_div) + 1)) % 16) <= int'(duty_code));
            tag = invert_burst ? "R5/R7 burst on space" : "R5/R6 burst on mark";
         end
         e_svc = wm_empty ? (q.size() == 0) : (q.size() <= 4);
         chk(tag, ir_out, e_out);
         chk("R4 busy", busy, m_active);
         chk("R2 level", fifo_level, q.size());
         chk("R2 full", fifo_full, q.size() == 8);
         chk("R10 svc_req", svc_req, e_svc);
         chk("R11 irq", irq, e_svc && irq_enable);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic put(bit mark, int dur);
      @(negedge clk);
      wr_en = 1'b1; wr_data = {mark, 16'(dur)};
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      do begin @(negedge clk); n++; end while ((busy || fifo_level != 0) && n < 20000);
      @(negedge clk);
   endtask

   initial begin
      int blen;
      bit seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;
      // R1 reset state
      chk("R1 ir_out", ir_out, 0);
      chk("R1 busy", busy, 0);
      chk("R1 level", fifo_level, 0);
      chk("R1 full", fifo_full, 0);
      chk("R1 svc_req", svc_req, 1);
      chk("R1 irq", irq, 0);
      chk_on = 1;

      // R3/R8: unmodulated, measured length
      clk_div = 16'd1; mod_enable = 0;
      put(1, 2); put(0, 1); put(1, 0);
      @(negedge clk); tx_enable = 1;
      blen = 0; seen = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (busy) begin blen++; seen = 1; end
         else if (seen) break;
      end
      chk("R3 burst length", blen, 48);
      wait_idle();

      // R6: modulated, marks burst
      mod_enable = 1; duty_code = 4'd5; clk_div = 16'd0;
      tx_enable = 0;
      put(1, 5); put(0, 3); put(1, 7);
      tx_enable = 1;
      wait_idle();

      // R7: inverted polarity
      invert_burst = 1; duty_code = 4'd3; clk_div = 16'd2;
      tx_enable = 0;
      put(1, 2); put(0, 6); put(1, 1); put(0, 0);
      tx_enable = 1;
      wait_idle();

      // R5: duty extremes
      invert_burst = 0;
      duty_code = 4'd15; put(1, 4); wait_idle();
      duty_code = 4'd0;  put(1, 9); wait_idle();

      // R2/R10/R11: overfill with transmitter off, then drain
      tx_enable = 0; irq_enable = 1; clk_div = 16'd0; duty_code = 4'd7;
      for (int i = 0; i < 10; i++) put(i[0], i % 3);
      @(negedge clk); #2;
      chk("R2 overfill level", fifo_level, 8);
      chk("R2 overfill full", fifo_full, 1);
      chk("R10 svc at full", svc_req, 0);
      tx_enable = 1;
      repeat (30) @(negedge clk);
      wm_empty = 1;
      wait_idle();
      wm_empty = 0; irq_enable = 0;

      // R12: disable mid-burst keeps queue
      mod_enable = 0;
      tx_enable = 0;
      put(1, 8); put(0, 8); put(1, 8);
      tx_enable = 1;
      repeat (10) @(negedge clk);
      tx_enable = 0;
      @(negedge clk); #2;
      chk("R12 busy after disable", busy, 0);
      chk("R12 ir_out after disable", ir_out, 0);
      chk("R12 records kept", fifo_level, 2);
      repeat (20) @(negedge clk);
      #2 chk("R12 queue untouched", fifo_level, 2);
      put(0, 1);
      tx_enable = 1;
      wait_idle();

      repeat (5) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule